// File: doc/BRIEF.md
# Preemptive Thread Work Window

This block holds a small set of threads that a scheduler has made ready. It feeds one of them at a time to an execution core. Each slot keeps a context number, a program counter and an instruction line that was fetched while the thread waited. A rotating pointer selects the slot whose thread issues. The pointer moves on when that thread blocks, or when it has issued for a programmable number of cycles in a row, so that no thread can starve the others.

A thread that blocks leaves the running set right away. It is handed back to the scheduler together with a tag that names the data it is waiting for. Empty slots ask for new threads through a refill port.

Both the refill port and the retire port use valid/ready. Refill back-pressure: `fill_ready` is low while every slot is occupied, and the scheduler must hold `fill_valid` and its payload until a cycle in which `fill_ready` is high. Retire back-pressure: once `retire_valid` rises, the offered thread and its tag stay unchanged until `retire_ready` is seen high, and the slot stays occupied until that acceptance. The run-length limit is a plain control register, written through `lim_we`/`lim_val`.

Top module: `work_window`

## Requirements
- R1: The window has SLOTS entries (default 8). `fill_ready` is high exactly when at least one slot is empty. A fill in a cycle with `fill_valid && fill_ready` writes context, PC and line into the lowest-numbered empty slot in that one cycle, and the slot is running from the next cycle on.
- R2: `issue_valid` is high exactly when the slot under the pointer is running. `issue_slot`, `issue_ctx`, `issue_pc` and `issue_line` then show that slot's index and contents.
- R3: When `block_in` is high in a cycle where `issue_valid` is high, the active slot becomes waiting and stores `block_tag`. In the next cycle the pointer sits on the first running slot found in circular ascending order after it. If there is none, the pointer stays where it is.
- R4: With a limit L other than 0, a slot that has issued L cycles in a row without blocking is swapped out. The pointer moves to the first running slot in circular ascending order after it, and the slot itself is checked last. A limit of 0 turns preemption off.
- R5: The limit register resets to DEF_LIMIT (default 4). A write with `lim_we` takes effect from the next cycle. A count that already meets or passes a newly lowered limit swaps out at once.
- R6: A slot's run counter clears when a thread is loaded into it and when that slot is swapped out, so each thread starts every turn with a full quota of L cycles.
- R7: Empty and waiting slots are skipped. When the pointer is not on a running slot, it moves in the next cycle to the first running slot in circular order. With no running slot, `issue_valid` is low.
- R8: `retire_valid` offers a waiting slot, with its context, PC and tag. When nothing is being held, the lowest-numbered waiting slot is offered. An offer that is not accepted stays unchanged in the following cycle. An accepted slot is empty in the next cycle.
- R9: `block_in` has no effect in a cycle where `issue_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_we | input | 1 | Write strobe for the run-length limit |
| lim_val | input | RUN_W | New run-length limit (0 turns preemption off) |
| fill_valid | input | 1 | Refill thread offered |
| fill_ready | output | 1 | An empty slot is available |
| fill_ctx | input | CTX_W | Context number of the refill thread |
| fill_pc | input | PC_W | Program counter of the refill thread |
| fill_line | input | LINE_W | Prefetched instruction line |
| issue_valid | output | 1 | Active slot holds a running thread |
| issue_slot | output | $clog2(SLOTS) | Index of the active slot |
| issue_ctx | output | CTX_W | Context of the active thread |
| issue_pc | output | PC_W | PC of the active thread |
| issue_line | output | LINE_W | Instruction line of the active thread |
| block_in | input | 1 | Active thread blocks this cycle |
| block_tag | input | TAG_W | Data item the thread blocks on |
| retire_valid | output | 1 | A blocked thread is offered to the scheduler |
| retire_ready | input | 1 | Scheduler accepts the offered thread |
| retire_ctx | output | CTX_W | Context of the retiring thread |
| retire_pc | output | PC_W | PC of the retiring thread |
| retire_tag | output | TAG_W | Blocking-data tag of the retiring thread |

## Verification
The bench targets these corner cases:
- A thread that is alone in the window and reaches its limit must keep issuing. A design that searched past the current slot only would leave the window idle.
- A block on the last running thread must drop `issue_valid`, not re-issue a waiting slot.
- When the limit is lowered below a live count, or set to 1 or 0, the swap must happen at once, every cycle, or never. An off-by-one compare shows up as one extra or one missing issue cycle per turn.
- While the retire port is stalled and a lower-numbered slot blocks, the offered thread must not change. A retire path without a hold would switch to the new slot in the middle of a handshake.

// File: rtl/ww_pkg.sv
package ww_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY = 2'd0,
    SL_RUN   = 2'd1,
    SL_WAIT  = 2'd2
  } slot_st_e;
endpackage

// File: rtl/ww_pick.sv
module ww_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ww_slots.sv
module ww_slots
  import ww_pkg::*;
#(
  parameter int N      = 8,
  parameter int IW     = $clog2(N),
  parameter int CTX_W  = 6,
  parameter int PC_W   = 16,
  parameter int LINE_W = 64,
  parameter int TAG_W  = 8,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we,
  input  logic [IW-1:0]     fill_idx,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [PC_W-1:0]   fill_pc,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              blk_we,
  input  logic [IW-1:0]     act_idx,
  input  logic [TAG_W-1:0]  blk_tag,
  input  logic              clr_we,
  input  logic [IW-1:0]     clr_idx,
  input  logic              cnt_inc,
  input  logic              cnt_clr,
  output logic [N-1:0]      run_mask,
  output logic [N-1:0]      wait_mask,
  output logic [N-1:0]      empty_mask,
  output logic [CTX_W-1:0]  ctx_q  [N],
  output logic [PC_W-1:0]   pc_q   [N],
  output logic [LINE_W-1:0] line_q [N],
  output logic [TAG_W-1:0]  tag_q  [N],
  output logic [RUN_W-1:0]  cnt_q  [N]
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    slot_st_e st;
    logic     load, here;

    assign load = fill_we && (fill_idx == IW'(g));
    assign here = (act_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)                              st <= SL_EMPTY;
      else if (load)                           st <= SL_RUN;
      else if (blk_we && here)                 st <= SL_WAIT;
      else if (clr_we && clr_idx == IW'(g))    st <= SL_EMPTY;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctx_q[g]  <= '0;
        pc_q[g]   <= '0;
        line_q[g] <= '0;
        tag_q[g]  <= '0;
        cnt_q[g]  <= '0;
      end else begin
        if (load) begin
          ctx_q[g]  <= fill_ctx;
          pc_q[g]   <= fill_pc;
          line_q[g] <= fill_line;
        end
        if (blk_we && here) tag_q[g] <= blk_tag;
        if (load)                   cnt_q[g] <= '0;
        else if (here && cnt_clr)   cnt_q[g] <= '0;
        else if (here && cnt_inc)   cnt_q[g] <= cnt_q[g] + 1'b1;
      end
    end

    assign run_mask[g]   = (st == SL_RUN);
    assign wait_mask[g]  = (st == SL_WAIT);
    assign empty_mask[g] = (st == SL_EMPTY);
  end

  AST_FILL_EMPTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> empty_mask[fill_idx]);                                   // R1
  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> empty_mask[$past(clr_idx)]);                              // R8
endmodule

// File: rtl/ww_rotor.sv
module ww_rotor #(
  parameter int N         = 8,
  parameter int IW        = $clog2(N),
  parameter int RUN_W     = 8,
  parameter int DEF_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     run_mask,
  input  logic             block_in,
  input  logic [RUN_W-1:0] cnt_act,
  input  logic             lim_we,
  input  logic [RUN_W-1:0] lim_val,
  output logic [IW-1:0]    ptr,
  output logic             active,
  output logic             blk_ok,
  output logic             swap,
  output logic [RUN_W-1:0] limit
);
  logic [N-1:0]  cand;
  logic [IW-1:0] nxt;
  logic          move;

  assign active = run_mask[ptr];
  assign blk_ok = active && block_in;
  assign swap   = active && !block_in && (limit != '0) &&
                  ({1'b0, cnt_act} + 1'b1 >= {1'b0, limit});
  assign move   = !active || blk_ok || swap;

  always_comb begin
    int  j;
    logic hit;
    cand = run_mask;
    if (blk_ok) cand[ptr] = 1'b0;
    nxt = ptr;
    hit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(ptr) + k) % N;
      if (!hit && cand[j]) begin
        nxt = IW'(j);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      limit <= RUN_W'(DEF_LIMIT);
    end else begin
      if (move)   ptr   <= nxt;
      if (lim_we) limit <= lim_val;
    end
  end

  AST_BLOCK_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ok |=> (ptr != $past(ptr)) || !active);                          // R3
  AST_IDLE_FINDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && run_mask != '0) |=> active || $past(run_mask) == '0 || run_mask == '0); // R7
endmodule

// File: rtl/work_window.sv
module work_window
  import ww_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int CTX_W     = 6,
  parameter int PC_W      = 16,
  parameter int LINE_W    = 64,
  parameter int TAG_W     = 8,
  parameter int RUN_W     = 8,
  parameter int DEF_LIMIT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lim_we,
  input  logic [RUN_W-1:0]         lim_val,
  input  logic                     fill_valid,
  output logic                     fill_ready,
  input  logic [CTX_W-1:0]         fill_ctx,
  input  logic [PC_W-1:0]          fill_pc,
  input  logic [LINE_W-1:0]        fill_line,
  output logic                     issue_valid,
  output logic [$clog2(SLOTS)-1:0] issue_slot,
  output logic [CTX_W-1:0]         issue_ctx,
  output logic [PC_W-1:0]          issue_pc,
  output logic [LINE_W-1:0]        issue_line,
  input  logic                     block_in,
  input  logic [TAG_W-1:0]         block_tag,
  output logic                     retire_valid,
  input  logic                     retire_ready,
  output logic [CTX_W-1:0]         retire_ctx,
  output logic [PC_W-1:0]          retire_pc,
  output logic [TAG_W-1:0]         retire_tag
);
  localparam int IW = $clog2(SLOTS);

  logic [SLOTS-1:0]  run_mask, wait_mask, empty_mask;
  logic [CTX_W-1:0]  ctx_q  [SLOTS];
  logic [PC_W-1:0]   pc_q   [SLOTS];
  logic [LINE_W-1:0] line_q [SLOTS];
  logic [TAG_W-1:0]  tag_q  [SLOTS];
  logic [RUN_W-1:0]  cnt_q  [SLOTS];

  logic [IW-1:0]    ptr, fill_idx, wpick_idx, ret_idx, held_idx;
  logic             active, blk_ok, swap, wpick_found, held;
  logic [RUN_W-1:0] limit;

  ww_pick #(.N(SLOTS), .IW(IW)) u_fill_pick (
    .req(empty_mask), .found(fill_ready), .idx(fill_idx));

  ww_pick #(.N(SLOTS), .IW(IW)) u_wait_pick (
    .req(wait_mask), .found(wpick_found), .idx(wpick_idx));

  ww_rotor #(.N(SLOTS), .IW(IW), .RUN_W(RUN_W), .DEF_LIMIT(DEF_LIMIT)) u_rotor (
    .clk(clk), .rst_n(rst_n), .run_mask(run_mask), .block_in(block_in),
    .cnt_act(cnt_q[ptr]), .lim_we(lim_we), .lim_val(lim_val),
    .ptr(ptr), .active(active), .blk_ok(blk_ok), .swap(swap), .limit(limit));

  ww_slots #(.N(SLOTS), .IW(IW), .CTX_W(CTX_W), .PC_W(PC_W), .LINE_W(LINE_W),
             .TAG_W(TAG_W), .RUN_W(RUN_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .fill_we(fill_valid && fill_ready), .fill_idx(fill_idx),
    .fill_ctx(fill_ctx), .fill_pc(fill_pc), .fill_line(fill_line),
    .blk_we(blk_ok), .act_idx(ptr), .blk_tag(block_tag),
    .clr_we(retire_valid && retire_ready), .clr_idx(ret_idx),
    .cnt_inc(active && !blk_ok), .cnt_clr(swap),
    .run_mask(run_mask), .wait_mask(wait_mask), .empty_mask(empty_mask),
    .ctx_q(ctx_q), .pc_q(pc_q), .line_q(line_q), .tag_q(tag_q), .cnt_q(cnt_q));

  // Retire offer: lowest waiting slot, frozen while the scheduler stalls.
  assign ret_idx      = held ? held_idx : wpick_idx;
  assign retire_valid = held || wpick_found;
  assign retire_ctx   = ctx_q[ret_idx];
  assign retire_pc    = pc_q[ret_idx];
  assign retire_tag   = tag_q[ret_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_idx <= '0;
    end else begin
      held     <= retire_valid && !retire_ready;
      held_idx <= ret_idx;
    end
  end

  assign issue_valid = active;
  assign issue_slot  = ptr;
  assign issue_ctx   = ctx_q[ptr];
  assign issue_pc    = pc_q[ptr];
  assign issue_line  = line_q[ptr];

  AST_RETIRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !retire_ready) |=>
      retire_valid && $stable(retire_ctx) && $stable(retire_tag) && $stable(retire_pc)); // R8
  AST_RUN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && limit != '0 && !$past(lim_we)) |-> cnt_q[ptr] < limit);       // R4
  AST_FRESH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=> cnt_q[$past(fill_idx)] == '0);                 // R6
endmodule

// File: tb/tb_work_window.sv
`timescale 1ns/1ps
module tb_work_window;
  localparam int N = 8, CW = 6, PW = 16, LW = 64, TW = 8, RW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lim_we = 0, fill_valid = 0, block_in = 0, retire_ready = 0;
  logic [RW-1:0] lim_val = '0;
  logic [CW-1:0] fill_ctx = '0;
  logic [PW-1:0] fill_pc = '0;
  logic [LW-1:0] fill_line = '0;
  logic [TW-1:0] block_tag = '0;
  logic fill_ready, issue_valid, retire_valid;
  logic [2:0] issue_slot;
  logic [CW-1:0] issue_ctx, retire_ctx;
  logic [PW-1:0] issue_pc, retire_pc;
  logic [LW-1:0] issue_line;
  logic [TW-1:0] retire_tag;

  always #2 clk = ~clk;

  work_window dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int m_st[N];  // 0 empty, 1 running, 2 waiting
  logic [CW-1:0] m_ctx[N];
  logic [PW-1:0] m_pc[N];
  logic [LW-1:0] m_line[N];
  logic [TW-1:0] m_tag[N];
  int m_cnt[N];
  int m_ptr, m_lim, m_hold;
  bit m_lock;
  bit [31:0] rng = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int first_run_after(int p, bit skip_self);
    for (int k = 1; k <= N; k++) begin
      int j = (p + k) % N;
      if (m_st[j] == 1 && !(skip_self && j == p)) return j;
    end
    return p;
  endfunction

  function automatic int ret_pick();
    if (m_lock) return m_hold;
    for (int i = 0; i < N; i++) if (m_st[i] == 2) return i;
    return -1;
  endfunction

  function automatic int empty_pick();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  task automatic compare();
    bit iv = (m_st[m_ptr] == 1);
    int r = ret_pick();
    int e = empty_pick();
    check(issue_valid == iv, "R2 R7 R9 issue_valid", 64'(issue_valid), 64'(iv));
    if (iv) begin
      check(issue_slot == 3'(m_ptr), "R3 R4 R6 issue_slot", 64'(issue_slot), 64'(m_ptr));
      check(issue_ctx == m_ctx[m_ptr] && issue_pc == m_pc[m_ptr], "R2 issue ctx/pc",
            {issue_ctx, issue_pc}, {m_ctx[m_ptr], m_pc[m_ptr]});
      check(issue_line == m_line[m_ptr], "R2 issue_line", issue_line, m_line[m_ptr]);
    end
    check(fill_ready == (e >= 0), "R1 fill_ready", 64'(fill_ready), 64'(e >= 0));
    check(retire_valid == (r >= 0), "R8 retire_valid", 64'(retire_valid), 64'(r >= 0));
    if (r >= 0)
      check(retire_ctx == m_ctx[r] && retire_tag == m_tag[r] && retire_pc == m_pc[r],
            "R8 retire payload", {retire_ctx, retire_tag, retire_pc}, {m_ctx[r], m_tag[r], m_pc[r]});
  endtask

  task automatic model_step();
    bit iv = (m_st[m_ptr] == 1);
    bit b  = iv && block_in;
    bit sw = iv && !b && m_lim != 0 && (m_cnt[m_ptr] + 1 >= m_lim);
    int r  = ret_pick();
    int e  = empty_pick();
    int p  = m_ptr;
    int np = m_ptr;
    if (b) np = first_run_after(p, 1);
    else if (!iv || sw) np = first_run_after(p, 0);
    if (iv && !b) m_cnt[p] = sw ? 0 : m_cnt[p] + 1;
    if (b) begin m_st[p] = 2; m_tag[p] = block_tag; end
    m_lock = (r >= 0) && !retire_ready;
    if (r >= 0) m_hold = r;
    if (r >= 0 && retire_ready) m_st[r] = 0;
    if (fill_valid && e >= 0) begin
      m_st[e] = 1; m_ctx[e] = fill_ctx; m_pc[e] = fill_pc; m_line[e] = fill_line; m_cnt[e] = 0;
    end
    if (lim_we) m_lim = int'(lim_val);
    m_ptr = np;
  endtask

  function automatic bit [31:0] xs(bit [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic drive(int c);
    rng = xs(rng);
    lim_we = 0; fill_valid = 0; block_in = 0; retire_ready = 1;
    fill_ctx = rng[5:0]; fill_pc = rng[31:16]; fill_line = {rng, ~rng};
    block_tag = rng[15:8];
    if (c >= 3 && c <= 5) fill_valid = 1;                       // R1 three threads
    else if (c == 41) begin lim_we = 1; lim_val = 8'd1; end     // R5 limit 1
    else if (c == 71) begin lim_we = 1; lim_val = 8'd0; end     // R4 preemption off
    else if (c == 91) begin lim_we = 1; lim_val = 8'd3; end
    else if (c > 91 && c <= 400) begin
      block_in = (rng[3:2] == 2'b00);
      fill_valid = rng[4];
      retire_ready = rng[5];
      if (rng[11:7] == 5'd0) begin lim_we = 1; lim_val = {5'd0, rng[14:12]}; end
    end else if (c > 400 && c <= 430) begin
      block_in = 1; retire_ready = 0;                           // R7 all waiting
    end else if (c > 430) begin
      block_in = 1;                                             // R9 block while idle
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_ctx[i] = '0; m_pc[i] = '0; m_line[i] = '0; m_tag[i] = '0; m_cnt[i] = 0;
    end
    m_ptr = 0; m_lim = 4; m_lock = 0; m_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(issue_valid == 0, "R7 reset issue_valid", 64'(issue_valid), 64'(0));
    check(fill_ready == 1, "R1 reset fill_ready", 64'(fill_ready), 64'(1));
    check(retire_valid == 0, "R8 reset retire_valid", 64'(retire_valid), 64'(0));
    for (int c = 0; c < 470; c++) begin
      @(negedge clk);
      drive(c);
      #1;
      compare();
      if (c == 20) check(issue_valid == 1, "R4 R6 rotation with default limit", 64'(issue_valid), 64'(1));
      model_step();
    end
    @(negedge clk);
    #1;
    check(issue_valid == 0 && retire_valid == 0 && fill_ready == 1, "R7 R8 drained window",
          {issue_valid, retire_valid, fill_ready}, 3'b001);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule